// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

The block is a host-side controller for a 16-bit asynchronous parallel memory or peripheral on separate address and data buses. It takes one read or write at a time on a valid/ready request port. It decodes the target chip-select from the upper address bits, and then plays out one access. During the access, chip-select, address-valid, output-enable and write-enable each go low and high on tick offsets that software programs for that chip-select.

All timing is counted in functional-clock ticks from a 5-bit field. A per-chip-select granularity bit doubles every field, so slow devices that need a window longer than 31 ticks can still be served without slowing the functional clock. A divider field produces a slower interface clock for the device. The divider changes only that exported clock and never the strobe timing. After an access, an idle gap holds off the next access to the same chip-select. An access to a different chip-select starts without that gap.

Top module: `async_strobe_seq`

## Requirements
- R1: Tick 0 is the first clock cycle after a request is accepted. A strobe is low on ticks t with on <= t < off. If off <= on, the strobe stays high for the whole access. Output-enable goes low only on reads and write-enable goes low only on writes.
- R2: Chip-select and address-valid each take their deassert tick from a read-specific field on reads and from a write-specific field on writes. Only the chip-select matched by the address goes low, and never more than one at a time.
- R3: With the granularity bit set, every timing field of that chip-select (strobe edges, access tick, cycle length, gap) counts as twice its programmed value.
- R4: An access lasts max(cycle,1) ticks, using the read cycle field or the write cycle field. The request ready signal is low throughout.
- R5: Read data is sampled at the end of tick min(access, last tick). rsp_valid_o pulses for one cycle after the last tick, with the sampled data on rsp_rdata_o. Writes give no response.
- R6: On writes, mem_dq_oe_o is high from the write-enable on tick to the last tick of the access, and mem_dq_o carries the write data. The data bus is never driven while output-enable is low.
- R7: After an access, a request to the same chip-select waits the scaled gap count of cycles in addition to the one ready cycle. A request to a different chip-select, or to no region, is accepted during the gap.
- R8: Region n matches when its enable is set and (addr[29:24] & mask) equals (base & mask). The lowest matching index wins. An unmatched request is accepted, moves no strobe and, on a read, gets rsp_valid_o in the next cycle with data 0.
- R9: mem_clk_o is low outside accesses. During an access with divider field d (period P=d+1), it is high on ticks where t mod P < (P+1)/2 for P>1, and equals the functional clock for P=1. The divider has no effect on strobe timing.
- R10: mem_addr_o carries request address bits [23:1] from acceptance and holds them through the access.
- R11: Out of reset, ready is high, all strobes are high, the data bus is released, and rsp_valid_o and mem_clk_o are low.
- R12: Timing is captured at acceptance. Changing the configuration inputs during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | functional clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request present |
| req_ready_o | output | 1 | request accepted on this edge when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | byte address |
| req_wdata_i | input | DATA_W | write data |
| rsp_valid_o | output | 1 | read data valid pulse |
| rsp_rdata_o | output | DATA_W | read data |
| cfg_timing_i | input | NUM_CS x TIMING_W | packed timing record per chip-select |
| cfg_base_i | input | NUM_CS x (ADDR_W-REGION_LSB) | region base per chip-select |
| cfg_mask_i | input | NUM_CS x (ADDR_W-REGION_LSB) | region mask per chip-select |
| cfg_en_i | input | NUM_CS | region enable per chip-select |
| mem_cs_no | output | NUM_CS | chip-selects, active low |
| mem_adv_no | output | 1 | address valid, active low |
| mem_oe_no | output | 1 | output enable, active low |
| mem_we_no | output | 1 | write enable, active low |
| mem_addr_o | output | REGION_LSB-1 | word address to device |
| mem_dq_o | output | DATA_W | data to device |
| mem_dq_oe_o | output | 1 | data bus drive enable |
| mem_dq_i | input | DATA_W | data from device |
| mem_clk_o | output | 1 | divided interface clock |

## Verification
Reads and writes run on two chip-selects whose edge settings differ, so swapping the read and write deassert fields or the two cycle lengths shows up as a wrong edge. The device data changes every cycle, so a sample taken one tick early or late returns a different word. Back-to-back requests to the same chip-select and to alternating chip-selects show the difference between keeping the gap and skipping it. Runs with the granularity bit set, every divider value, inverted on/off pairs, a zero cycle length, overlapping, disabled and unmatched regions, and a configuration change in mid-access test scaling, clock independence, priority and capture.

// File: rtl/asq_pkg.sv
package asq_pkg;
  localparam int TF_W = 5;
  localparam int TS_W = TF_W + 1;

  typedef struct packed {
    logic            gran;
    logic [1:0]      div;
    logic [TF_W-1:0] cs_on;
    logic [TF_W-1:0] cs_rd_off;
    logic [TF_W-1:0] cs_wr_off;
    logic [TF_W-1:0] adv_on;
    logic [TF_W-1:0] adv_rd_off;
    logic [TF_W-1:0] adv_wr_off;
    logic [TF_W-1:0] oe_on;
    logic [TF_W-1:0] oe_off;
    logic [TF_W-1:0] we_on;
    logic [TF_W-1:0] we_off;
    logic [TF_W-1:0] rd_acc;
    logic [TF_W-1:0] rd_cyc;
    logic [TF_W-1:0] wr_cyc;
    logic [TF_W-1:0] c2c;
  } timing_cfg_t;

  localparam int TIMING_W = $bits(timing_cfg_t);

  // resolved, scaled timing for one access
  typedef struct packed {
    logic [TS_W-1:0] cs_on;
    logic [TS_W-1:0] cs_off;
    logic [TS_W-1:0] adv_on;
    logic [TS_W-1:0] adv_off;
    logic [TS_W-1:0] oe_on;
    logic [TS_W-1:0] oe_off;
    logic [TS_W-1:0] we_on;
    logic [TS_W-1:0] we_off;
    logic [TS_W-1:0] cap;
    logic [TS_W-1:0] last;
    logic [TS_W-1:0] c2c;
    logic [1:0]      div;
  } access_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_GAP} state_e;

  function automatic logic [TS_W-1:0] scale(input logic [TF_W-1:0] v, input logic g);
    return g ? {v, 1'b0} : {1'b0, v};
  endfunction

  function automatic access_t build(input timing_cfg_t c, input logic wr);
    access_t a;
    logic [TS_W-1:0] cyc, acc;
    a.cs_on   = scale(c.cs_on, c.gran);
    a.cs_off  = scale(wr ? c.cs_wr_off : c.cs_rd_off, c.gran);
    a.adv_on  = scale(c.adv_on, c.gran);
    a.adv_off = scale(wr ? c.adv_wr_off : c.adv_rd_off, c.gran);
    a.oe_on   = wr ? '0 : scale(c.oe_on, c.gran);
    a.oe_off  = wr ? '0 : scale(c.oe_off, c.gran);
    a.we_on   = wr ? scale(c.we_on, c.gran) : '0;
    a.we_off  = wr ? scale(c.we_off, c.gran) : '0;
    cyc       = scale(wr ? c.wr_cyc : c.rd_cyc, c.gran);
    a.last    = (cyc == '0) ? '0 : cyc - TS_W'(1);
    acc       = scale(c.rd_acc, c.gran);
    a.cap     = (acc > a.last) ? a.last : acc;
    a.c2c     = scale(c.c2c, c.gran);
    a.div     = c.div;
    return a;
  endfunction
endpackage

// File: rtl/asq_region_dec.sv
module asq_region_dec #(
  parameter int NUM_CS     = 2,
  parameter int ADDR_W     = 30,
  parameter int REGION_LSB = 24,
  parameter int IDX_W      = 1
) (
  input  logic [ADDR_W-1:0]                         addr_i,
  input  logic [NUM_CS-1:0][ADDR_W-REGION_LSB-1:0]  base_i,
  input  logic [NUM_CS-1:0][ADDR_W-REGION_LSB-1:0]  mask_i,
  input  logic [NUM_CS-1:0]                         en_i,
  output logic                                      hit_o,
  output logic [IDX_W-1:0]                          idx_o
);
  logic [NUM_CS-1:0] match;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    assign match[g] = en_i[g] &&
      ((addr_i[ADDR_W-1:REGION_LSB] & mask_i[g]) == (base_i[g] & mask_i[g]));
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/asq_strobe_win.sv
module asq_strobe_win #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tick_i,
  input  logic [W-1:0] on_i,
  input  logic [W-1:0] off_i,
  input  logic         run_i,
  output logic         active_o
);
  assign active_o = run_i && (tick_i >= on_i) && (tick_i < off_i);

  a_r1_window_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (off_i > on_i));
endmodule

// File: rtl/asq_clk_div.sv
module asq_clk_div (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [1:0] div_i,
  output logic       clk_o
);
  logic [1:0] phase_q;
  logic [1:0] half;

  assign half = 2'((3'(div_i) + 3'd2) >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (start_i) phase_q <= '0;
    else if (run_i)   phase_q <= (phase_q == div_i) ? '0 : phase_q + 2'd1;
  end

  // divide-by-1 passes the functional clock through while running
  assign clk_o = run_i && ((div_i == 2'd0) ? clk_i : (phase_q < half));

  a_r9_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (phase_q <= div_i));
endmodule

// File: rtl/async_strobe_seq.sv
module async_strobe_seq #(
  parameter int NUM_CS     = 2,
  parameter int ADDR_W     = 30,
  parameter int REGION_LSB = 24,
  parameter int DATA_W     = 16
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       req_valid_i,
  output logic                                       req_ready_o,
  input  logic                                       req_write_i,
  input  logic [ADDR_W-1:0]                          req_addr_i,
  input  logic [DATA_W-1:0]                          req_wdata_i,
  output logic                                       rsp_valid_o,
  output logic [DATA_W-1:0]                          rsp_rdata_o,
  input  logic [NUM_CS-1:0][asq_pkg::TIMING_W-1:0]   cfg_timing_i,
  input  logic [NUM_CS-1:0][ADDR_W-REGION_LSB-1:0]   cfg_base_i,
  input  logic [NUM_CS-1:0][ADDR_W-REGION_LSB-1:0]   cfg_mask_i,
  input  logic [NUM_CS-1:0]                          cfg_en_i,
  output logic [NUM_CS-1:0]                          mem_cs_no,
  output logic                                       mem_adv_no,
  output logic                                       mem_oe_no,
  output logic                                       mem_we_no,
  output logic [REGION_LSB-2:0]                      mem_addr_o,
  output logic [DATA_W-1:0]                          mem_dq_o,
  output logic                                       mem_dq_oe_o,
  input  logic [DATA_W-1:0]                          mem_dq_i,
  output logic                                       mem_clk_o
);
  import asq_pkg::*;

  localparam int IDX_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int NUM_STROBE = 4;
  localparam int S_CS = 0, S_ADV = 1, S_OE = 2, S_WE = 3;

  state_e                 state_q;
  logic [TS_W-1:0]        tick_q, gap_q;
  access_t                acc_q, next_acc;
  logic [IDX_W-1:0]       cs_q, idx;
  logic                   wr_q, hit, busy, accept, last_tick;
  logic [REGION_LSB-2:0]  addr_q;
  logic [DATA_W-1:0]      wdata_q, rdata_q;
  logic                   rsp_q;
  timing_cfg_t            sel_cfg;

  asq_region_dec #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .IDX_W(IDX_W)
  ) u_dec (
    .addr_i(req_addr_i), .base_i(cfg_base_i), .mask_i(cfg_mask_i),
    .en_i(cfg_en_i), .hit_o(hit), .idx_o(idx)
  );

  assign busy        = (state_q == ST_BUSY);
  assign last_tick   = busy && (tick_q == acc_q.last);
  assign req_ready_o = (state_q == ST_IDLE) ||
                       ((state_q == ST_GAP) && (!hit || (idx != cs_q)));
  assign accept      = req_valid_i && req_ready_o;
  assign sel_cfg     = timing_cfg_t'(cfg_timing_i[idx]);
  assign next_acc    = build(sel_cfg, req_write_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      gap_q   <= '0;
      acc_q   <= '0;
      cs_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        ST_BUSY: begin
          if (tick_q == acc_q.cap) rdata_q <= mem_dq_i;
          if (last_tick) begin
            rsp_q <= !wr_q;
            if (acc_q.c2c != '0) begin
              state_q <= ST_GAP;
              gap_q   <= acc_q.c2c;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            tick_q <= tick_q + TS_W'(1);
          end
        end
        ST_GAP: begin
          if (gap_q == TS_W'(1)) state_q <= ST_IDLE;
          gap_q <= gap_q - TS_W'(1);
        end
        default: ;
      endcase
      if (accept) begin
        if (hit) begin
          state_q <= ST_BUSY;
          tick_q  <= '0;
          acc_q   <= next_acc;
          cs_q    <= idx;
          wr_q    <= req_write_i;
          addr_q  <= req_addr_i[REGION_LSB-1:1];
          wdata_q <= req_wdata_i;
        end else if (!req_write_i) begin
          rsp_q   <= 1'b1;
          rdata_q <= '0;
        end
      end
    end
  end

  logic [NUM_STROBE-1:0][TS_W-1:0] win_on, win_off;
  logic [NUM_STROBE-1:0]           win_act;

  always_comb begin
    win_on[S_CS]   = acc_q.cs_on;   win_off[S_CS]  = acc_q.cs_off;
    win_on[S_ADV]  = acc_q.adv_on;  win_off[S_ADV] = acc_q.adv_off;
    win_on[S_OE]   = acc_q.oe_on;   win_off[S_OE]  = acc_q.oe_off;
    win_on[S_WE]   = acc_q.we_on;   win_off[S_WE]  = acc_q.we_off;
  end

  for (genvar g = 0; g < NUM_STROBE; g++) begin : g_win
    asq_strobe_win #(.W(TS_W)) u_win (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_q), .on_i(win_on[g]),
      .off_i(win_off[g]), .run_i(busy), .active_o(win_act[g])
    );
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign mem_cs_no[g] = !(win_act[S_CS] && (cs_q == IDX_W'(g)));
  end

  assign mem_adv_no  = !win_act[S_ADV];
  assign mem_oe_no   = !win_act[S_OE];
  assign mem_we_no   = !win_act[S_WE];
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = busy && wr_q && (tick_q >= acc_q.we_on);
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

  asq_clk_div u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept && hit), .run_i(busy),
    .div_i(acc_q.div), .clk_o(mem_clk_o)
  );

  a_r4_no_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !req_ready_o);
  a_r2_single_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));
  a_r1_oe_we_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  a_r10_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last_tick) |=> $stable(mem_addr_o));
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (&mem_cs_no && mem_adv_no && mem_oe_no && mem_we_no && !mem_dq_oe_o));
endmodule

// File: tb/async_strobe_seq_tb_top.sv
module async_strobe_seq_tb_top;
  import asq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req_valid = 0, req_write = 0, req_ready, rsp_valid, adv_n, oe_n, we_n, dq_oe, mclk;
  logic [29:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, dq_o, dq_i = '0;
  logic [NCS-1:0][TIMING_W-1:0] cfg_t = '0;
  logic [NCS-1:0][5:0] cfg_b = '0, cfg_m = '0;
  logic [NCS-1:0] cfg_en = '0, cs_n;
  logic [22:0] maddr;

  async_strobe_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .cfg_timing_i(cfg_t),
    .cfg_base_i(cfg_b), .cfg_mask_i(cfg_m), .cfg_en_i(cfg_en), .mem_cs_no(cs_n),
    .mem_adv_no(adv_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_addr_o(maddr),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i), .mem_clk_o(mclk)
  );

  int checks = 0, errors = 0, cyc = 0;
  int oe_lo = 0, we_lo = 0, cs_lo0 = 0, cs_lo1 = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic timing_cfg_t mk(int cs_on, int cs_roff, int cs_woff, int adv_on,
      int adv_roff, int adv_woff, int oe_on, int oe_off, int we_on, int we_off,
      int acc, int rcyc, int wcyc, int c2c, int gran, int div);
    timing_cfg_t c;
    c.cs_on = 5'(cs_on); c.cs_rd_off = 5'(cs_roff); c.cs_wr_off = 5'(cs_woff);
    c.adv_on = 5'(adv_on); c.adv_rd_off = 5'(adv_roff); c.adv_wr_off = 5'(adv_woff);
    c.oe_on = 5'(oe_on); c.oe_off = 5'(oe_off); c.we_on = 5'(we_on); c.we_off = 5'(we_off);
    c.rd_acc = 5'(acc); c.rd_cyc = 5'(rcyc); c.wr_cyc = 5'(wcyc); c.c2c = 5'(c2c);
    c.gran = 1'(gran); c.div = 2'(div);
    return c;
  endfunction

  // ---- behavioural reference model ----
  int m_st = 0, m_t = 0, m_gap = 0, m_cs = 0, m_rsp = 0, m_rd = 0, m_wd = 0;
  bit m_wr = 0;
  logic [29:0] m_addr = '0;
  timing_cfg_t m_cfg = '0;

  function automatic int decode(logic [29:0] a);
    for (int i = 0; i < NCS; i++)
      if (cfg_en[i] && ((a[29:24] & cfg_m[i]) == (cfg_b[i] & cfg_m[i]))) return i;
    return -1;
  endfunction
  function automatic int sc(int v); return m_cfg.gran ? 2 * v : v; endfunction
  function automatic int m_last();
    int c = sc(m_wr ? int'(m_cfg.wr_cyc) : int'(m_cfg.rd_cyc));
    return (c == 0) ? 0 : c - 1;
  endfunction
  function automatic bit exp_ready();
    int d = decode(req_addr);
    return (m_st == 0) || (m_st == 2 && (d < 0 || d != m_cs));
  endfunction
  function automatic bit win(int on, int off);
    return (m_st == 1) && (m_t >= on) && (m_t < off);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_gap = 0; m_cs = 0; m_rsp = 0; m_rd = 0; m_wd = 0;
      m_wr = 0; m_addr = '0; m_cfg = '0;
    end else begin
      int d; bit acc; int capv;
      d = decode(req_addr);
      acc = req_valid && exp_ready();
      m_rsp = 0;
      if (m_st == 1) begin
        capv = sc(int'(m_cfg.rd_acc));
        if (capv > m_last()) capv = m_last();
        if (m_t == capv) m_rd = int'(dq_i);
        if (m_t == m_last()) begin
          m_rsp = m_wr ? 0 : 1;
          if (sc(int'(m_cfg.c2c)) > 0) begin m_st = 2; m_gap = sc(int'(m_cfg.c2c)); end
          else m_st = 0;
        end else m_t++;
      end else if (m_st == 2) begin
        m_gap--;
        if (m_gap == 0) m_st = 0;
      end
      if (acc) begin
        if (d >= 0) begin
          m_st = 1; m_t = 0; m_cfg = timing_cfg_t'(cfg_t[d]); m_cs = d;
          m_wr = req_write; m_addr = req_addr; m_wd = int'(req_wdata);
        end else if (!req_write) begin
          m_rsp = 1; m_rd = 0;
        end
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) dq_i = 16'h5A00 + 16'(cyc[7:0]);

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int p, csoff, advoff;
      bit ecs, eoe, ewe, edq, eclk;
      p = int'(m_cfg.div) + 1;
      csoff  = sc(m_wr ? int'(m_cfg.cs_wr_off) : int'(m_cfg.cs_rd_off));
      advoff = sc(m_wr ? int'(m_cfg.adv_wr_off) : int'(m_cfg.adv_rd_off));
      ecs = win(sc(int'(m_cfg.cs_on)), csoff);
      for (int i = 0; i < NCS; i++)
        chk("R2 cs_n", int'(cs_n[i]), (ecs && i == m_cs) ? 0 : 1);
      chk("R2 adv_n", int'(adv_n), win(sc(int'(m_cfg.adv_on)), advoff) ? 0 : 1);
      eoe = !m_wr && win(sc(int'(m_cfg.oe_on)), sc(int'(m_cfg.oe_off)));
      ewe = m_wr && win(sc(int'(m_cfg.we_on)), sc(int'(m_cfg.we_off)));
      chk("R1 oe_n", int'(oe_n), eoe ? 0 : 1);
      chk("R1 we_n", int'(we_n), ewe ? 0 : 1);
      edq = (m_st == 1) && m_wr && (m_t >= sc(int'(m_cfg.we_on)));
      chk("R6 dq_oe", int'(dq_oe), int'(edq));
      if (edq) chk("R6 dq_o", int'(dq_o), m_wd);
      chk("R10 addr", int'(maddr), int'(m_addr[23:1]));
      chk("R7 ready", int'(req_ready), int'(exp_ready()));
      chk("R5 rsp_valid", int'(rsp_valid), m_rsp);
      if (m_rsp != 0) chk("R5 rsp_data", int'(rsp_rdata), m_rd);
      eclk = (m_st == 1) && (p > 1) && ((m_t % p) < (p + 1) / 2);
      chk("R9 mem_clk", int'(mclk), int'(eclk));
      if (!oe_n) oe_lo++;
      if (!we_n) we_lo++;
      if (!cs_n[0]) cs_lo0++;
      if (!cs_n[1]) cs_lo1++;
    end
  end

  task automatic clr(); oe_lo = 0; we_lo = 0; cs_lo0 = 0; cs_lo1 = 0; endtask

  task automatic issue(input bit wr, input logic [29:0] a, input logic [15:0] d,
                       output int acc_cyc);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc + 1;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic settle(); repeat (80) @(negedge clk); endtask

  localparam logic [29:0] A0 = 30'h0100_0ABC, A1 = 30'h0200_1234, AX = 30'h0500_0002;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int c0, c1;
    timing_cfg_t ca, cb;
    ca = mk(1, 12, 14, 0, 3, 4, 2, 10, 3, 11, 9, 13, 15, 3, 0, 0);
    cb = mk(0, 7, 9, 1, 2, 5, 1, 6, 2, 8, 4, 8, 10, 0, 0, 2);
    cfg_t[0] = ca; cfg_t[1] = cb;
    cfg_b[0] = 6'd1; cfg_b[1] = 6'd2; cfg_m = {6'h3f, 6'h3f}; cfg_en = 2'b11;
    repeat (3) @(negedge clk);
    #2;
    // R11 reset state
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 cs_n", int'(cs_n), 3);
    chk("R11 oe/we/adv", int'({oe_n, we_n, adv_n}), 7);
    chk("R11 dq_oe/rsp/clk", int'({dq_oe, rsp_valid, mclk}), 0);
    rst_n = 1;
    settle();

    clr(); issue(0, A0, 0, c0); settle();
    chk("R1 read oe window", oe_lo, 8);
    chk("R1 read no we", we_lo, 0);
    chk("R2 read cs window", cs_lo0, 11);
    clr(); issue(1, A0, 16'hBEEF, c0); settle();
    chk("R1 write we window", we_lo, 8);
    chk("R2 write cs window", cs_lo0, 13);

    // R7 same chip-select keeps the gap, other skips it
    issue(0, A0, 0, c0); issue(0, A0, 0, c1);
    chk("R7 same-cs spacing", c1 - c0, 17);
    settle();
    issue(0, A0, 0, c0); issue(0, A1, 0, c1);
    chk("R7 cross-cs spacing", c1 - c0, 14);
    settle();
    issue(1, A0, 16'h1234, c0); issue(0, A1, 0, c1);
    chk("R4 write cycle length", c1 - c0, 16);
    settle();

    // R9 divider values on cs1, strobes unchanged
    for (int dv = 0; dv < 4; dv++) begin
      cb.div = 2'(dv); cfg_t[1] = cb;
      clr(); issue(0, A1, 0, c0); settle();
      chk("R9 oe window independent of divider", oe_lo, 5);
    end

    // R3 granularity
    ca.gran = 1; cfg_t[0] = ca;
    clr(); issue(0, A0, 0, c0); issue(0, A0, 0, c1);
    chk("R3 doubled spacing", c1 - c0, 33);
    settle();
    chk("R3 doubled oe window", oe_lo, 32);
    ca.gran = 0;

    // R1 inverted / equal edges
    cfg_t[0] = mk(9, 4, 4, 5, 5, 5, 10, 10, 6, 6, 3, 12, 12, 0, 0, 0);
    clr(); issue(0, A0, 0, c0); issue(1, A0, 16'h0F0F, c1); settle();
    chk("R1 off<=on keeps strobes high", oe_lo + we_lo + cs_lo0, 0);

    // R5 zero cycle, access beyond end
    cfg_t[0] = mk(0, 1, 1, 0, 1, 1, 0, 1, 0, 1, 20, 0, 0, 2, 0, 0);
    issue(0, A0, 0, c0); issue(0, A1, 0, c1);
    chk("R5 zero cycle spacing", c1 - c0, 2);
    settle();

    // R12 change timing mid-access
    cfg_t[0] = ca;
    clr(); issue(0, A0, 0, c0);
    cfg_t[0] = mk(1, 30, 30, 0, 30, 30, 0, 30, 0, 30, 29, 31, 31, 9, 1, 3);
    settle();
    chk("R12 captured oe window", oe_lo, 8);
    cfg_t[0] = ca;

    // R8 unmatched, disabled, priority
    clr(); issue(0, AX, 0, c0); @(negedge clk); #2;
    chk("R8 unmatched rsp", int'(rsp_valid), 1);
    chk("R8 unmatched data", int'(rsp_rdata), 0);
    settle();
    chk("R8 unmatched no strobe", cs_lo0 + cs_lo1 + oe_lo, 0);
    cfg_en[1] = 0;
    clr(); issue(0, A1, 0, c0); settle();
    chk("R8 disabled region", cs_lo1, 0);
    cfg_en[1] = 1; cfg_b[1] = 6'd1;
    clr(); issue(0, A0, 0, c0); settle();
    chk("R8 priority lowest index", cs_lo1, 0);
    chk("R8 priority cs0 used", cs_lo0, 11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule